// File: doc/BRIEF.md
# Machine Timer with Compare Interrupt

This block is a machine-level timer for one hardware thread. It keeps a 64-bit time counter and a 64-bit compare value, and it holds a level interrupt request high for as long as the time value is at or above the compare value. The comparison is unsigned. The request is not a one-shot pulse. Software lowers it by moving the compare value beyond the current time.

Both 64-bit values sit behind a plain 32-bit register bus, so each one takes two word addresses. A read-only word reports the counter's tick frequency, which lets software find the timebase. The counter advances by one in every clock cycle where the `tick` input is high, so the rate is constant and is set by the platform. Software may write the counter at any time.

Top module: `mach_timer`

## Requirements
- R1: Synchronous active-high reset clears the time counter to zero and sets every bit of the compare value to one. While reset is held and just after it, `timer_irq` is low.
- R2: Outside reset, with no counter write, the time counter rises by one after each clock edge where `tick` is high. It holds its value when `tick` is low.
- R3: An increment carries from bit 31 into bit 32. The counter wraps from all ones to zero.
- R4: A bus write to a counter half replaces only that half, from the next clock edge. In that cycle no increment is applied, even if `tick` is high.
- R5: A bus write to a compare half replaces only that half, from the next clock edge. The other half and the time counter are untouched, and the counter still increments in that cycle.
- R6: `timer_irq` equals the unsigned test time >= compare on the registered values. It rises in the cycle the counter reaches the compare value and stays high while that test holds.
- R7: When a compare write makes the test false, `timer_irq` is low in the cycle after that write.
- R8: The word at byte offset 0x10 reads as the `TIMEBASE_HZ` parameter. A write to it has no effect.
- R9: The byte offsets are: 0x00 counter bits 31:0, 0x04 counter bits 63:32, 0x08 compare bits 31:0, 0x0C compare bits 63:32. Reads are combinational. Each of the following reads as zero and writes nothing: any other offset, an offset whose low two bits are nonzero, and any access with `bus_sel` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Counter advance enable; sets the timebase |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | ADDR_W (5) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| timer_irq | output | 1 | Level timer interrupt request |

## Verification
The bench builds the block with its default values: a 64-bit counter, a 32-bit bus, a 5-bit address and a 10 MHz timebase word. Because the counter can be written, the bench can preload values just below the 32-bit carry and just below full wrap. Both boundaries are then reached in a few ticks rather than 2^32 cycles. The same preloading lets the bench place the compare value a few ticks ahead of time, and it allows a compare value with bit 63 set, which tells an unsigned compare from a signed one.

// File: rtl/mach_timer_pkg.sv
package mach_timer_pkg;

  parameter int MT_BUS_W  = 32;
  parameter int MT_TIME_W = 64;
  localparam int MT_HALVES = MT_TIME_W / MT_BUS_W;
  localparam int MT_NREG   = 2 * MT_HALVES + 1;

  typedef logic [MT_TIME_W-1:0] mt_time_t;
  typedef logic [MT_BUS_W-1:0]  mt_word_t;

  // Unsigned greater-or-equal, formed as "no borrow out of a - b".
  function automatic logic mt_at_or_past(mt_time_t a, mt_time_t b);
    logic [MT_TIME_W:0] diff;
    diff = {1'b0, a} - {1'b0, b};
    return ~diff[MT_TIME_W];
  endfunction

  // One timebase step; wraps to zero from all ones.
  function automatic mt_time_t mt_step(mt_time_t t);
    return t + mt_time_t'(1);
  endfunction

  // Replace the selected bus-wide slices of a value.
  function automatic mt_time_t mt_merge(mt_time_t old, logic [MT_HALVES-1:0] sel,
                                        mt_word_t w);
    mt_time_t r;
    r = old;
    for (int h = 0; h < MT_HALVES; h++) begin
      if (sel[h]) r[h*MT_BUS_W +: MT_BUS_W] = w;
    end
    return r;
  endfunction

endpackage

// File: rtl/mt_regdec.sv
module mt_regdec
  import mach_timer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                    sel,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  output logic [MT_HALVES-1:0]    wr_time,
  output logic [MT_HALVES-1:0]    wr_cmp,
  output logic [MT_NREG-1:0]      rd_hit
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] word_idx;
  logic             wr_en;

  assign aligned  = (addr[1:0] == 2'b00);
  assign word_idx = addr[ADDR_W-1:2];
  assign wr_en    = sel && we && aligned;

  for (genvar h = 0; h < MT_HALVES; h++) begin : g_half
    assign wr_time[h] = wr_en && (word_idx == IDX_W'(h));
    assign wr_cmp[h]  = wr_en && (word_idx == IDX_W'(MT_HALVES + h));
  end

  for (genvar r = 0; r < MT_NREG; r++) begin : g_rd
    assign rd_hit[r] = sel && aligned && (word_idx == IDX_W'(r));
  end
endmodule

// File: rtl/mt_counter.sv
module mt_counter
  import mach_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [MT_HALVES-1:0] wr_half,
  input  mt_word_t             wdata,
  output mt_time_t             time_q
);
  mt_time_t time_d;

  always_comb begin
    if (|wr_half)  time_d = mt_merge(time_q, wr_half, wdata);
    else if (tick) time_d = mt_step(time_q);
    else           time_d = time_q;
  end

  always_ff @(posedge clk) begin
    if (rst) time_q <= '0;
    else     time_q <= time_d;
  end
endmodule

// File: rtl/mt_compare.sv
module mt_compare
  import mach_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [MT_HALVES-1:0] wr_half,
  input  mt_word_t             wdata,
  input  mt_time_t             time_q,
  output mt_time_t             cmp_q,
  output logic                 irq
);
  always_ff @(posedge clk) begin
    if (rst)             cmp_q <= '1;
    else if (|wr_half)   cmp_q <= mt_merge(cmp_q, wr_half, wdata);
  end

  assign irq = mt_at_or_past(time_q, cmp_q);
endmodule

// File: rtl/mach_timer.sv
module mach_timer
  import mach_timer_pkg::*;
#(
  parameter int          ADDR_W      = 5,
  parameter int unsigned TIMEBASE_HZ = 10_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              timer_irq
);
  localparam int FREQ_IDX = 2 * MT_HALVES;

  logic [MT_HALVES-1:0] wr_time;
  logic [MT_HALVES-1:0] wr_cmp;
  logic [MT_NREG-1:0]   rd_hit;
  mt_time_t             time_q;
  mt_time_t             cmp_q;
  logic                 irq;

  mt_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .sel     (bus_sel),
    .we      (bus_we),
    .addr    (bus_addr),
    .wr_time (wr_time),
    .wr_cmp  (wr_cmp),
    .rd_hit  (rd_hit)
  );

  mt_counter u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wr_half (wr_time),
    .wdata   (bus_wdata),
    .time_q  (time_q)
  );

  mt_compare u_cmp (
    .clk     (clk),
    .rst     (rst),
    .wr_half (wr_cmp),
    .wdata   (bus_wdata),
    .time_q  (time_q),
    .cmp_q   (cmp_q),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    for (int h = 0; h < MT_HALVES; h++) begin
      if (rd_hit[h])             bus_rdata = time_q[h*MT_BUS_W +: MT_BUS_W];
      if (rd_hit[MT_HALVES + h]) bus_rdata = cmp_q[h*MT_BUS_W +: MT_BUS_W];
    end
    if (rd_hit[FREQ_IDX]) bus_rdata = 32'(TIMEBASE_HZ);
  end

  assign timer_irq = irq;
endmodule

// File: rtl/mach_timer_chk.sv
module mach_timer_chk
  import mach_timer_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 tick,
  input logic [MT_HALVES-1:0] wr_time,
  input logic [MT_HALVES-1:0] wr_cmp,
  input logic [31:0]          bus_wdata,
  input mt_time_t             time_q,
  input mt_time_t             cmp_q,
  input logic                 timer_irq
);
  localparam int TOP = MT_TIME_W - 1;

  // R2
  inc_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !(|wr_time)) |=> (time_q == $past(time_q) + 64'd1));

  // R2
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !(|wr_time)) |=> $stable(time_q));

  // R4
  time_low_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_time[0] |=> (time_q[MT_BUS_W-1:0] == $past(bus_wdata)) &&
                   (time_q[TOP -: MT_BUS_W] == $past(time_q[TOP -: MT_BUS_W])));

  // R4
  time_high_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_time[MT_HALVES-1] |=> (time_q[TOP -: MT_BUS_W] == $past(bus_wdata)) &&
                             (time_q[MT_BUS_W-1:0] == $past(time_q[MT_BUS_W-1:0])));

  // R5
  cmp_low_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cmp[0] |=> (cmp_q[MT_BUS_W-1:0] == $past(bus_wdata)) &&
                  (cmp_q[TOP -: MT_BUS_W] == $past(cmp_q[TOP -: MT_BUS_W])));

  // R5
  cmp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(|wr_cmp) |=> $stable(cmp_q));

  // R6
  zero_cmp_fires_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_q == '0) |-> timer_irq);

  // R7
  cmp_moved_up_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cmp[MT_HALVES-1] && !tick && !(|wr_time) &&
     ({bus_wdata, cmp_q[MT_BUS_W-1:0]} > time_q)) |=> !timer_irq);
endmodule

bind mach_timer mach_timer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .wr_time   (wr_time),
  .wr_cmp    (wr_cmp),
  .bus_wdata (bus_wdata),
  .time_q    (time_q),
  .cmp_q     (cmp_q),
  .timer_irq (timer_irq)
);

// File: tb/mach_timer_test.sv
module mach_timer_test;
  localparam int unsigned FREQ = 10_000_000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        timer_irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Behavioural reference state.
  logic [63:0] m_time = '0;
  logic [63:0] m_cmp  = '1;

  mach_timer #(.ADDR_W(5), .TIMEBASE_HZ(FREQ)) uut (
    .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timer_irq(timer_irq)
  );

  always #5 clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Advance one clock, update the model from the applied inputs, then
  // compare the interrupt with the model away from the edge.
  task automatic cycle();
    logic [63:0] nt;
    logic [63:0] nc;
    logic        wr;
    logic        aligned;
    nt = m_time;
    nc = m_cmp;
    aligned = (bus_addr[1:0] == 2'b00);
    wr = bus_sel && bus_we && aligned;
    if (rst) begin
      nt = 64'd0;
      nc = {64{1'b1}};
    end else begin
      if (wr && bus_addr[4:2] == 3'd0)      nt[31:0]  = bus_wdata;
      else if (wr && bus_addr[4:2] == 3'd1) nt[63:32] = bus_wdata;
      else if (tick)                        nt = m_time + 64'd1;
      if (wr && bus_addr[4:2] == 3'd2) nc[31:0]  = bus_wdata;
      if (wr && bus_addr[4:2] == 3'd3) nc[63:32] = bus_wdata;
    end
    @(posedge clk);
    m_time = nt;
    m_cmp  = nc;
    @(negedge clk);
    check("R6 irq vs model", {63'd0, timer_irq}, {63'd0, (m_time >= m_cmp)});
  endtask

  task automatic idle(int n, logic tk);
    tick = tk;
    for (int i = 0; i < n; i++) cycle();
    tick = 1'b0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, logic tk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick = tk;
    cycle();
    bus_sel = 1'b0; bus_we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic s, output logic [31:0] d);
    bus_sel = s; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_model_check(logic [4:0] a, string req);
    logic [31:0] d;
    logic [31:0] e;
    rd(a, 1'b1, d);
    case (a)
      5'h00: e = m_time[31:0];
      5'h04: e = m_time[63:32];
      5'h08: e = m_cmp[31:0];
      5'h0C: e = m_cmp[63:32];
      5'h10: e = FREQ;
      default: e = 32'd0;
    endcase
    check(req, {32'd0, d}, {32'd0, e});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    @(negedge clk);
    idle(3, 1'b1);            // R1: tick ignored under reset
    rst = 1'b0;
    // R1 reset state
    rd(5'h00, 1'b1, d); check("R1 time low", {32'd0, d}, 64'd0);
    rd(5'h04, 1'b1, d); check("R1 time high", {32'd0, d}, 64'd0);
    rd(5'h0C, 1'b1, d); check("R1 compare high", {32'd0, d}, 64'hFFFF_FFFF);
    check("R1 irq low", {63'd0, timer_irq}, 64'd0);

    // R2 counting under several tick patterns
    idle(5, 1'b1);
    rd(5'h00, 1'b1, d); check("R2 five ticks", {32'd0, d}, 64'd5);
    idle(4, 1'b0);
    rd(5'h00, 1'b1, d); check("R2 hold", {32'd0, d}, 64'd5);
    for (int i = 0; i < 6; i++) idle(1, logic'(i % 2));
    rd(5'h00, 1'b1, d); check("R2 alternating", {32'd0, d}, 64'd8);

    // R3 carry across bit 31
    wr(5'h00, 32'hFFFF_FFFE, 1'b0);
    idle(3, 1'b1);
    rd(5'h00, 1'b1, d); check("R3 carry low", {32'd0, d}, 64'd1);
    rd(5'h04, 1'b1, d); check("R3 carry high", {32'd0, d}, 64'd1);

    // R4 write with tick high takes no increment, high half untouched
    wr(5'h00, 32'h0000_0100, 1'b1);
    rd(5'h00, 1'b1, d); check("R4 no increment", {32'd0, d}, 64'h100);
    rd(5'h04, 1'b1, d); check("R4 other half kept", {32'd0, d}, 64'd1);
    idle(1, 1'b1);
    rd(5'h00, 1'b1, d); check("R4 then counts", {32'd0, d}, 64'h101);

    // R5/R6 crossing: time 0x1000, compare 0x1003
    wr(5'h04, 32'd0, 1'b0);
    wr(5'h00, 32'h1000, 1'b0);
    wr(5'h08, 32'h1003, 1'b1);   // R5: counter still advances
    rd(5'h00, 1'b1, d); check("R5 tick during compare write", {32'd0, d}, 64'h1001);
    rd(5'h0C, 1'b1, d); check("R5 high half kept", {32'd0, d}, 64'hFFFF_FFFF);
    wr(5'h0C, 32'd0, 1'b0);
    check("R6 below compare", {63'd0, timer_irq}, 64'd0);
    idle(1, 1'b1);
    check("R6 one short", {63'd0, timer_irq}, 64'd0);
    idle(1, 1'b1);
    check("R6 rises at equal", {63'd0, timer_irq}, 64'd1);
    idle(3, 1'b0);
    check("R6 level held", {63'd0, timer_irq}, 64'd1);

    // R7 compare moved forward drops irq next cycle
    wr(5'h0C, 32'd1, 1'b0);
    check("R7 drops after rewrite", {63'd0, timer_irq}, 64'd0);

    // R6 unsigned: compare bit 63 set must not look negative
    wr(5'h0C, 32'h8000_0000, 1'b0);
    check("R6 unsigned high cmp", {63'd0, timer_irq}, 64'd0);
    wr(5'h04, 32'hFFFF_FFFF, 1'b0);
    check("R6 unsigned time above", {63'd0, timer_irq}, 64'd1);

    // R3 full wrap
    wr(5'h00, 32'hFFFF_FFFF, 1'b0);
    idle(1, 1'b1);
    rd(5'h00, 1'b1, d); check("R3 wrap low", {32'd0, d}, 64'd0);
    rd(5'h04, 1'b1, d); check("R3 wrap high", {32'd0, d}, 64'd0);

    // R8 timebase word, read-only
    rd(5'h10, 1'b1, d); check("R8 timebase", {32'd0, d}, 64'(FREQ));
    wr(5'h10, 32'h1234_5678, 1'b0);
    rd(5'h10, 1'b1, d); check("R8 write ignored", {32'd0, d}, 64'(FREQ));

    // R9 unmapped, misaligned and unselected accesses
    rd(5'h14, 1'b1, d); check("R9 unmapped read", {32'd0, d}, 64'd0);
    rd(5'h00, 1'b0, d); check("R9 unselected read", {32'd0, d}, 64'd0);
    wr(5'h01, 32'hDEAD_BEEF, 1'b0);
    rd(5'h00, 1'b1, d); check("R9 misaligned write", {32'd0, d}, 64'd0);
    rd(5'h01, 1'b1, d); check("R9 misaligned read", {32'd0, d}, 64'd0);
    bus_sel = 1'b0; bus_we = 1'b1; bus_addr = 5'h08; bus_wdata = 32'h5;
    cycle();
    bus_we = 1'b0;
    rd(5'h08, 1'b1, d); check("R9 write without select", {32'd0, d}, 64'h1003);

    // R9 full map against the model
    rd_model_check(5'h00, "R9 map time low");
    rd_model_check(5'h04, "R9 map time high");
    rd_model_check(5'h08, "R9 map cmp low");
    rd_model_check(5'h0C, "R9 map cmp high");

    // R1 reset again mid-run
    rst = 1'b1;
    idle(2, 1'b1);
    rst = 1'b0;
    rd(5'h08, 1'b1, d); check("R1 compare low after reset", {32'd0, d}, 64'hFFFF_FFFF);
    rd_model_check(5'h00, "R1 time after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule